// File: doc/BRIEF.md
# Stereo Output Channel Router

This block is a datapath stage placed between decoded left/right audio samples and a DAC core. For every accepted sample pair it decides what each of the two outputs carries: silence, the left input, the right input, or the midpoint of the two. Each output has its own 2-bit source code, so the same block covers ordinary stereo, swapped channels, mono and full mute.

After routing, each output is scaled by a digital attenuator. The attenuator takes an 8-bit code with 0.5 dB steps below unity. A link control lets the left attenuation code govern both outputs, so one value sets the volume of the whole pair. Samples arrive with a single valid strobe. The result appears one clock later with its own valid strobe. Control inputs are sampled only on cycles that carry a sample.

Top module: `chroute_top`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly one clock. The outputs present while `out_valid` is high belong to the sample pair accepted on the previous clock.
- R2: `fmt[3:2]` selects the source of the left output and `fmt[1:0]` selects the source of the right output. Both use the same encoding: 2'b00 = zero, 2'b01 = right input, 2'b10 = left input, 2'b11 = midpoint.
- R3: `fmt` = 4'b1001 passes left to left and right to right. 4'b0110 swaps the two channels. 4'b1111 drives the midpoint on both outputs. 4'b0000 drives zero on both outputs.
- R4: The midpoint is floor((L+R)/2), computed with one guard bit. Full-scale inputs of equal sign therefore never wrap.
- R5: For an attenuation code c, code 8'hFF gives unity gain (the output equals the routed sample) and code 8'h00 forces zero. Any other code sets k = 255 - c and gain g = G[k mod 12] >> (k div 12), where G = 32768, 30935, 29205, 27571, 26029, 24573, 23198, 21900, 20675, 19519, 18427, 17396. The output is floor(sample * g / 32768).
- R6: While `att_link` is high, both outputs are scaled with `att_left`, and `att_right` has no effect.
- R7: While `att_link` is low, the left output is scaled with `att_left` and the right output with `att_right`.
- R8: On a clock where `in_valid` is low, the outputs keep their values. Changes to `fmt`, `att_link`, `att_left`, `att_right` or the sample inputs in that cycle have no effect.
- R9: While `rst` is high, `out_valid`, `out_left` and `out_right` are driven to zero on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample pair valid |
| in_left | input | DATA_W | Signed left input sample |
| in_right | input | DATA_W | Signed right input sample |
| fmt | input | 4 | Output source codes: [3:2] left output, [1:0] right output |
| att_link | input | 1 | Use the left attenuation code for both outputs |
| att_left | input | 8 | Attenuation code for the left output |
| att_right | input | 8 | Attenuation code for the right output |
| out_valid | output | 1 | Output sample pair valid |
| out_left | output | DATA_W | Signed left output sample |
| out_right | output | DATA_W | Signed right output sample |

## Verification
The hardest situation to provoke is a control change that lands on a cycle with no sample. Such a change must leave the outputs untouched, and it may only take effect with the next accepted pair. The stimulus inserts idle gaps and randomizes `fmt`, the link bit and both attenuation codes during those gaps. It then checks that the held outputs stay the same. Directed pairs at both full-scale extremes exercise the midpoint's guard bit, and directed codes 8'h00, 8'h01 and 8'hFF reach the ends of the gain range.

// File: rtl/chroute_pkg.sv
package chroute_pkg;

    localparam int ATT_W       = 8;
    localparam int GAIN_W      = 17;
    localparam int GAIN_FRAC   = 15;
    localparam int STEPS_OCT   = 12;
    localparam int ATT_MAX     = (1 << ATT_W) - 1;

    typedef enum logic [1:0] {
        SRC_ZERO  = 2'b00,
        SRC_RIGHT = 2'b01,
        SRC_LEFT  = 2'b10,
        SRC_MID   = 2'b11
    } src_sel_e;

    // gain of a fractional step within one 6 dB span, Q2.15
    function automatic logic [GAIN_W-1:0] step_gain(input logic [3:0] idx);
        logic [GAIN_W-1:0] g;
        case (idx)
            4'd0:    g = 17'd32768;
            4'd1:    g = 17'd30935;
            4'd2:    g = 17'd29205;
            4'd3:    g = 17'd27571;
            4'd4:    g = 17'd26029;
            4'd5:    g = 17'd24573;
            4'd6:    g = 17'd23198;
            4'd7:    g = 17'd21900;
            4'd8:    g = 17'd20675;
            4'd9:    g = 17'd19519;
            4'd10:   g = 17'd18427;
            4'd11:   g = 17'd17396;
            default: g = '0;
        endcase
        return g;
    endfunction

    function automatic logic [GAIN_W-1:0] code_to_gain(input logic [ATT_W-1:0] code);
        int k;
        logic [GAIN_W-1:0] g;
        if (code == '0) begin
            g = '0;
        end else begin
            k = ATT_MAX - int'(code);
            g = step_gain(4'(k % STEPS_OCT)) >> (k / STEPS_OCT);
        end
        return g;
    endfunction

endpackage

// File: rtl/chroute_mid.sv
module chroute_mid #(
    parameter int DATA_W = 24
) (
    input  logic signed [DATA_W-1:0] left_i,
    input  logic signed [DATA_W-1:0] right_i,
    output logic signed [DATA_W-1:0] mid_o
);
    localparam int SUM_W = DATA_W + 1;

    logic signed [SUM_W-1:0] sum;
    logic unused_lsb;

    assign sum        = {left_i[DATA_W-1], left_i} + {right_i[DATA_W-1], right_i};
    assign mid_o      = sum[SUM_W-1:1];
    assign unused_lsb = sum[0];
endmodule

// File: rtl/chroute_src_sel.sv
module chroute_src_sel
    import chroute_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  src_sel_e                 sel_i,
    input  logic signed [DATA_W-1:0] left_i,
    input  logic signed [DATA_W-1:0] right_i,
    input  logic signed [DATA_W-1:0] mid_i,
    output logic signed [DATA_W-1:0] sample_o
);
    always_comb begin
        unique case (sel_i)
            SRC_ZERO:  sample_o = '0;
            SRC_RIGHT: sample_o = right_i;
            SRC_LEFT:  sample_o = left_i;
            SRC_MID:   sample_o = mid_i;
            default:   sample_o = '0;
        endcase
    end
endmodule

// File: rtl/chroute_atten.sv
module chroute_atten
    import chroute_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic signed [DATA_W-1:0] sample_i,
    input  logic [ATT_W-1:0]         code_i,
    output logic signed [DATA_W-1:0] sample_o
);
    localparam int PROD_W = DATA_W + GAIN_W + 1;

    logic [GAIN_W-1:0]        gain;
    logic signed [GAIN_W:0]   gain_s;
    logic signed [PROD_W-1:0] prod;
    logic unused_bits;

    assign gain        = code_to_gain(code_i);
    assign gain_s      = $signed({1'b0, gain});
    assign prod        = PROD_W'(sample_i) * PROD_W'(gain_s);
    assign sample_o    = prod[GAIN_FRAC +: DATA_W];
    assign unused_bits = ^{prod[PROD_W-1:GAIN_FRAC+DATA_W], prod[GAIN_FRAC-1:0]};
endmodule

// File: rtl/chroute_top.sv
module chroute_top
    import chroute_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_left,
    input  logic signed [DATA_W-1:0] in_right,
    input  logic [3:0]               fmt,
    input  logic                     att_link,
    input  logic [ATT_W-1:0]         att_left,
    input  logic [ATT_W-1:0]         att_right,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_left,
    output logic signed [DATA_W-1:0] out_right
);
    localparam int NCH = 2;

    logic signed [DATA_W-1:0] mid;
    src_sel_e                 sel    [NCH];
    logic [ATT_W-1:0]         code   [NCH];
    logic signed [DATA_W-1:0] routed [NCH];
    logic signed [DATA_W-1:0] scaled [NCH];
    logic signed [DATA_W-1:0] q      [NCH];
    logic                     vld_q;

    chroute_mid #(.DATA_W(DATA_W)) u_mid (
        .left_i  (in_left),
        .right_i (in_right),
        .mid_o   (mid)
    );

    assign sel[0]  = src_sel_e'(fmt[3:2]);
    assign sel[1]  = src_sel_e'(fmt[1:0]);
    assign code[0] = att_left;
    assign code[1] = att_link ? att_left : att_right;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        chroute_src_sel #(.DATA_W(DATA_W)) u_sel (
            .sel_i    (sel[ch]),
            .left_i   (in_left),
            .right_i  (in_right),
            .mid_i    (mid),
            .sample_o (routed[ch])
        );

        chroute_atten #(.DATA_W(DATA_W)) u_att (
            .sample_i (routed[ch]),
            .code_i   (code[ch]),
            .sample_o (scaled[ch])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                q[ch] <= '0;
            end else if (in_valid) begin
                q[ch] <= scaled[ch];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) vld_q <= 1'b0;
        else     vld_q <= in_valid;
    end

    assign out_valid = vld_q;
    assign out_left  = q[0];
    assign out_right = q[1];
endmodule

// File: rtl/chroute_chk.sv
module chroute_chk
    import chroute_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic signed [DATA_W-1:0] in_left,
    input logic signed [DATA_W-1:0] in_right,
    input logic [3:0]               fmt,
    input logic                     att_link,
    input logic [ATT_W-1:0]         att_left,
    input logic [ATT_W-1:0]         att_right,
    input logic                     out_valid,
    input logic signed [DATA_W-1:0] out_left,
    input logic signed [DATA_W-1:0] out_right
);
    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R1
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R8
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_left) && $stable(out_right)));
    // R2
    left_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fmt[3:2] == 2'b00) |=> out_left == '0);
    // R2
    right_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fmt[1:0] == 2'b00) |=> out_right == '0);
    // R5
    att_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && att_left == '0) |=> out_left == '0);
    // R6
    link_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && att_link && att_left == '0) |=> out_right == '0);
    // R3
    stereo_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fmt == 4'b1001 && att_left == 8'hFF && !att_link && att_right == 8'hFF)
        |=> (out_left == $past(in_left) && out_right == $past(in_right)));
    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_left == '0 && out_right == '0));
endmodule

bind chroute_top chroute_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_left   (in_left),
    .in_right  (in_right),
    .fmt       (fmt),
    .att_link  (att_link),
    .att_left  (att_left),
    .att_right (att_right),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right)
);

// File: tb/chroute_top_tb.sv
`timescale 1ns/1ps
module chroute_top_tb;
    localparam int DW = 24;
    localparam longint MAXV = (64'sd1 <<< (DW-1)) - 1;
    localparam longint MINV = -(64'sd1 <<< (DW-1));

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] in_left = '0;
    logic signed [DW-1:0] in_right = '0;
    logic [3:0]           fmt = 4'b1001;
    logic                 att_link = 1'b0;
    logic [7:0]           att_left = 8'hFF;
    logic [7:0]           att_right = 8'hFF;
    logic                 out_valid;
    logic signed [DW-1:0] out_left;
    logic signed [DW-1:0] out_right;

    int checks = 0;
    int failures = 0;
    longint exp_l = 0;
    longint exp_r = 0;

    always #10 clk = ~clk;

    chroute_top #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_left(in_left),
        .in_right(in_right), .fmt(fmt), .att_link(att_link),
        .att_left(att_left), .att_right(att_right), .out_valid(out_valid),
        .out_left(out_left), .out_right(out_right)
    );

    function automatic longint gain_of(input int code);
        int tbl [12] = '{32768, 30935, 29205, 27571, 26029, 24573,
                         23198, 21900, 20675, 19519, 18427, 17396};
        int k;
        if (code == 0) return 0;
        k = 255 - code;
        return longint'(tbl[k % 12] >> (k / 12));
    endfunction

    function automatic longint pick(input logic [1:0] c, input longint l, input longint r);
        case (c)
            2'b00:   return 0;
            2'b01:   return r;
            2'b10:   return l;
            default: return (l + r) >>> 1;
        endcase
    endfunction

    function automatic longint scale(input longint s, input int code);
        return (s * gain_of(code)) >>> 15;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive at negedge, result checked at next negedge
    task automatic send(input logic v, input longint l, input longint r,
                        input logic [3:0] f, input logic lk,
                        input logic [7:0] al, input logic [7:0] ar, input string req);
        in_valid = v; in_left = DW'(l); in_right = DW'(r);
        fmt = f; att_link = lk; att_left = al; att_right = ar;
        if (v) begin
            exp_l = scale(pick(f[3:2], l, r), int'(al));
            exp_r = scale(pick(f[1:0], l, r), lk ? int'(al) : int'(ar));
        end
        @(posedge clk);
        @(negedge clk);
        check({req, " valid"}, longint'(out_valid), longint'(v));
        check({req, " left"}, longint'(out_left), exp_l);
        check({req, " right"}, longint'(out_right), exp_r);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 valid", longint'(out_valid), 0);
        check("R9 left", longint'(out_left), 0);
        check("R9 right", longint'(out_right), 0);
        rst = 1'b0;
        @(negedge clk);

        // R3 named combinations, R1 latency
        send(1, 1000, -2000, 4'b1001, 0, 8'hFF, 8'hFF, "R3 stereo R1");
        send(1, 1000, -2000, 4'b0110, 0, 8'hFF, 8'hFF, "R3 swap");
        send(1, 1001, -2000, 4'b1111, 0, 8'hFF, 8'hFF, "R3 mono R4");
        send(1, 1000, -2000, 4'b0000, 0, 8'hFF, 8'hFF, "R3 mute");
        // R2 mixed codes
        send(1, 77, 55, 4'b1101, 0, 8'hFF, 8'hFF, "R2 mid/right");
        send(1, 77, 55, 4'b0011, 0, 8'hFF, 8'hFF, "R2 zero/mid");
        // R4 full-scale midpoint
        send(1, MAXV, MAXV, 4'b1111, 0, 8'hFF, 8'hFF, "R4 max");
        send(1, MINV, MINV, 4'b1111, 0, 8'hFF, 8'hFF, "R4 min");
        send(1, MINV, MAXV, 4'b1111, 0, 8'hFF, 8'hFF, "R4 mixed");
        // R5 gain extremes
        send(1, MAXV, MINV, 4'b1001, 0, 8'h00, 8'h01, "R5 zero/lowest");
        send(1, MAXV, MINV, 4'b1001, 0, 8'hF3, 8'hFE, "R5 6dB/half-dB");
        send(1, -12345, 98765, 4'b1001, 0, 8'h80, 8'h40, "R5 R7 separate");
        // R6 link ignores att_right
        send(1, 5000, -5000, 4'b1001, 1, 8'hF0, 8'h00, "R6 link");
        send(1, 5000, -5000, 4'b1001, 1, 8'h00, 8'hFF, "R6 link zero");
        // R8 idle cycles with changing controls keep outputs
        send(1, 3000, 4000, 4'b1001, 0, 8'hFF, 8'hFF, "R8 load");
        send(0, 9999, -9999, 4'b0110, 1, 8'h10, 8'h20, "R8 hold1");
        send(0, -1, 1, 4'b0000, 0, 8'h00, 8'h00, "R8 hold2");
        send(1, 3000, 4000, 4'b1001, 0, 8'hFF, 8'hFF, "R8 resume");

        // random traffic with idle gaps
        for (int i = 0; i < 3000; i++) begin
            logic v;
            v = ($urandom % 4) != 0;
            send(v, longint'($signed(DW'($urandom))), longint'($signed(DW'($urandom))),
                 4'($urandom), 1'($urandom), 8'($urandom), 8'($urandom),
                 "R2 R5 R6 R7 R8 random");
        end

        // R9 reset mid-stream
        in_valid = 1'b1; rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R9 mid valid", longint'(out_valid), 0);
        check("R9 mid left", longint'(out_left), 0);
        check("R9 mid right", longint'(out_right), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule